// File: doc/BRIEF.md
# Scan-Driven Flash Programming Sequencer

This block turns whole-chip erase and page-write requests into the ordered chain of instruction-register and data-register scans that a microcontroller's test-port programming interface expects. An operation request carries an operation code, a byte address and a byte count. Page data comes from a byte stream that the block pops one byte at a time. Every scan is handed to a lower-level shift engine over a request/acknowledge port. The engine returns the captured data-register bits, and the sequencer uses them to find out whether the target has finished an erase or a page program.

Each operation starts by putting the target into programming mode and ends by taking it out again. Between those two steps the block either erases the chip or programs consecutive pages, padding the last partial page with 0xFF. The completion polling is bounded: a target that never reports ready makes the operation end with an error, and programming mode is still left cleanly. While an operation runs, the block holds busy. It pulses done once at the end, and error stays valid until the next accepted operation.

Top module: `jtag_flash_seq`

## Requirements
- R1: Every instruction scan is 4 bits long and uses these codes: target reset 0xC, programming enable 0x4, programming command 0x5, page load 0x6. Data scans carry their value right-aligned in `scan_din`, with all higher bits zero.
- R2: Every accepted operation begins with: instruction 0xC, a 1-bit data scan of 1, instruction 0x4, and a 16-bit data scan of 0xA370.
- R3: An erase (op_code 01) issues instruction 0x5 and then the 15-bit words 0x2380, 0x3180, 0x3380, 0x3380. It then polls with 0x3380.
- R4: Each page begins with instruction 0x5 and the 15-bit word 0x2310. Next come 0x0700 OR byte-address bits [16:9] and 0x0300 OR byte-address bits [8:1], and finally instruction 0x6.
- R5: Each page then sends exactly PAGE_BYTES 8-bit data scans. While bytes of the request remain, a scan carries `byte_data` and pulses `byte_pop` in its acknowledge cycle. Once they are used up, the scan carries 0xFF and there is no pop.
- R6: After the page data come instruction 0x5 and the 15-bit words 0x3700, 0x3500, 0x3700, 0x3700. The block then polls with 0x3700.
- R7: A write (op_code 10) enters programming mode once, programs consecutive pages at addresses that step by PAGE_BYTES until the count is used up, and leaves once. A count of zero enters and leaves with no page.
- R8: A write whose address is not a multiple of PAGE_BYTES is rejected with no scan: in the next cycle done and error are 1 and busy stays 0.
- R9: A poll repeats until bit 9 of the captured word is 1. If MAX_POLL polls in a row all capture bit 9 as 0, error is set, any remaining pages are skipped, and the leave sequence runs.
- R10: Only one scan is outstanding at a time. `scan_req` and its fields stay stable until `scan_ack`, and the next scan is presented no earlier than the cycle after the acknowledge.
- R11: Requests are ignored while busy, and also when op_code is 00 or 11.
- R12: done is 1 for exactly one cycle, the cycle after the final acknowledge, and busy is 0 in that cycle. error holds its value until the next accepted operation.
- R13: The leave sequence is: instruction 0x5, 15-bit words 0x2300 and 0x3300, instruction 0x4, a 16-bit scan of 0, instruction 0xC, and a 1-bit scan of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 2 | 01 erase, 10 write, others ignored |
| op_addr | input | ADDR_W | Byte address of the first page |
| op_count | input | CNT_W | Number of bytes to write |
| byte_data | input | 8 | Head byte of the page data stream |
| byte_pop | output | 1 | Head byte consumed this cycle |
| scan_req | output | 1 | Scan request to the shift engine |
| scan_is_ir | output | 1 | 1 instruction scan, 0 data scan |
| scan_len | output | 6 | Scan length in bits |
| scan_din | output | 32 | Bits to shift in |
| scan_ack | input | 1 | One-cycle scan completion |
| scan_dout | input | 32 | Captured bits, valid with scan_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operation rejected or timed out |

## Verification
The bench builds the block with PAGE_BYTES of 8 and MAX_POLL of 4, so the runs stay short. With 8-byte pages a multi-page write crosses several pages, a partial last page, and the step of address bit 9 from the low-word field into the high-word field. With a limit of 4 polls, both a late success and a timeout are reached within a few scans. The shift-engine model acknowledges with varying latency and returns not-ready words that have every bit except bit 9 set.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_ERASE = 2'b01,
      OP_WRITE = 2'b10,
      OP_RSVD  = 2'b11
   } op_e;

   typedef enum logic [2:0] {
      PH_ENTER,
      PH_ERASE,
      PH_WHEAD,
      PH_WDATA,
      PH_WTAIL,
      PH_POLL,
      PH_LEAVE
   } phase_e;

   localparam logic [3:0] IR_RESET = 4'hC;
   localparam logic [3:0] IR_PEN   = 4'h4;
   localparam logic [3:0] IR_PCMD  = 4'h5;
   localparam logic [3:0] IR_PLOAD = 4'h6;

   localparam int READY_BIT = 9;

   typedef struct packed {
      logic        is_ir;
      logic [5:0]  len;
      logic [31:0] bits;
   } scan_t;

endpackage

// File: rtl/flash_seq_steps.sv
module flash_seq_steps
   import flash_seq_pkg::*;
(
   input  phase_e      phase,
   input  logic [2:0]  step,
   input  logic [7:0]  addr_hi,
   input  logic [7:0]  addr_lo,
   input  logic [7:0]  fill_byte,
   input  logic [14:0] poll_word,
   output scan_t       scan,
   output logic        last
);

   function automatic scan_t ir(input logic [3:0] code);
      return '{is_ir: 1'b1, len: 6'd4, bits: {28'd0, code}};
   endfunction

   function automatic scan_t dr(input logic [5:0] n, input logic [15:0] v);
      return '{is_ir: 1'b0, len: n, bits: {16'd0, v}};
   endfunction

   function automatic scan_t cmd(input logic [14:0] w);
      return dr(6'd15, {1'b0, w});
   endfunction

   always_comb begin
      scan = '0;
      last = 1'b0;
      unique case (phase)
         PH_ENTER: begin
            case (step)
               3'd0: scan = ir(IR_RESET);
               3'd1: scan = dr(6'd1, 16'd1);
               3'd2: scan = ir(IR_PEN);
               default: begin scan = dr(6'd16, 16'hA370); last = 1'b1; end
            endcase
         end
         PH_ERASE: begin
            case (step)
               3'd0: scan = ir(IR_PCMD);
               3'd1: scan = cmd(15'h2380);
               3'd2: scan = cmd(15'h3180);
               3'd3: scan = cmd(15'h3380);
               default: begin scan = cmd(15'h3380); last = 1'b1; end
            endcase
         end
         PH_WHEAD: begin
            case (step)
               3'd0: scan = ir(IR_PCMD);
               3'd1: scan = cmd(15'h2310);
               3'd2: scan = cmd({7'h07, addr_hi});
               3'd3: scan = cmd({7'h03, addr_lo});
               default: begin scan = ir(IR_PLOAD); last = 1'b1; end
            endcase
         end
         PH_WDATA: scan = dr(6'd8, {8'd0, fill_byte});
         PH_WTAIL: begin
            case (step)
               3'd0: scan = ir(IR_PCMD);
               3'd1: scan = cmd(15'h3700);
               3'd2: scan = cmd(15'h3500);
               3'd3: scan = cmd(15'h3700);
               default: begin scan = cmd(15'h3700); last = 1'b1; end
            endcase
         end
         PH_POLL: scan = cmd(poll_word);
         PH_LEAVE: begin
            case (step)
               3'd0: scan = ir(IR_PCMD);
               3'd1: scan = cmd(15'h2300);
               3'd2: scan = cmd(15'h3300);
               3'd3: scan = ir(IR_PEN);
               3'd4: scan = dr(6'd16, 16'd0);
               3'd5: scan = ir(IR_RESET);
               default: begin scan = dr(6'd1, 16'd0); last = 1'b1; end
            endcase
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/flash_seq_poll.sv
module flash_seq_poll #(
   parameter int MAX_POLL = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic hit,
   input  logic ready,
   output logic expired
);

   generate
      if (MAX_POLL == 0) begin : g_unbounded
         logic unused_poll;
         assign unused_poll = ^{clk, rst_n, active, hit, ready};
         assign expired     = 1'b0;
      end else begin : g_bounded
         localparam int CW = $clog2(MAX_POLL + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt <= '0;
            else if (!active) cnt <= '0;
            else if (hit)     cnt <= cnt + 1'b1;
         end

         assign expired = hit && !ready && (cnt == CW'(MAX_POLL - 1));

         // R9
         poll_cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            active && hit && !ready && !expired |=> cnt < CW'(MAX_POLL));
      end
   endgenerate

endmodule

// File: rtl/jtag_flash_seq.sv
module jtag_flash_seq
   import flash_seq_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter int MAX_POLL   = 1024,
   parameter int ADDR_W     = 17,
   parameter int CNT_W      = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [CNT_W-1:0]  op_count,
   input  logic [7:0]        byte_data,
   output logic              byte_pop,
   output logic              scan_req,
   output logic              scan_is_ir,
   output logic [5:0]        scan_len,
   output logic [31:0]       scan_din,
   input  logic              scan_ack,
   input  logic [31:0]       scan_dout,
   output logic              busy,
   output logic              done,
   output logic              error
);

   localparam int PG_LOG = $clog2(PAGE_BYTES);

   generate
      if (PAGE_BYTES < 2 || (1 << PG_LOG) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (ADDR_W < 17) begin : g_bad_addr
         $error("ADDR_W must cover address bit 16");
      end
   endgenerate

   logic              busy_q, done_q, err_q;
   phase_e            phase_q;
   logic [2:0]        step_q;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [PG_LOG-1:0] bidx_q;

   scan_t       cur;
   logic        last;
   logic [7:0]  fill_byte;
   logic [14:0] poll_word;
   logic        expired, accept, misalign, ready;

   assign fill_byte = (left_q != '0) ? byte_data : 8'hFF;
   assign poll_word = (op_q == OP_ERASE) ? 15'h3380 : 15'h3700;
   assign ready     = scan_dout[READY_BIT];
   assign accept    = !busy_q && op_valid && (op_code == OP_ERASE || op_code == OP_WRITE);
   assign misalign  = |op_addr[PG_LOG-1:0];

   logic unused_dout;
   assign unused_dout = ^{scan_dout[31:READY_BIT+1], scan_dout[READY_BIT-1:0]};

   flash_seq_steps u_steps (
      .phase     (phase_q),
      .step      (step_q),
      .addr_hi   (addr_q[16:9]),
      .addr_lo   (addr_q[8:1]),
      .fill_byte (fill_byte),
      .poll_word (poll_word),
      .scan      (cur),
      .last      (last)
   );

   flash_seq_poll #(.MAX_POLL(MAX_POLL)) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (busy_q && phase_q == PH_POLL),
      .hit     (scan_ack),
      .ready   (ready),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         phase_q <= PH_ENTER;
         step_q  <= '0;
         op_q    <= OP_NONE;
         addr_q  <= '0;
         left_q  <= '0;
         bidx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            if (op_code == OP_WRITE && misalign) begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
            end else begin
               busy_q  <= 1'b1;
               err_q   <= 1'b0;
               phase_q <= PH_ENTER;
               step_q  <= '0;
               op_q    <= op_e'(op_code);
               addr_q  <= op_addr;
               left_q  <= op_count;
            end
         end else if (busy_q && scan_ack) begin
            step_q <= step_q + 3'd1;
            case (phase_q)
               PH_ENTER: if (last) begin
                  step_q <= '0;
                  if (op_q == OP_ERASE)  phase_q <= PH_ERASE;
                  else if (left_q == '0) phase_q <= PH_LEAVE;
                  else                   phase_q <= PH_WHEAD;
               end
               PH_ERASE, PH_WTAIL: if (last) begin
                  step_q  <= '0;
                  phase_q <= PH_POLL;
               end
               PH_WHEAD: if (last) begin
                  step_q  <= '0;
                  bidx_q  <= '0;
                  phase_q <= PH_WDATA;
               end
               PH_WDATA: begin
                  step_q <= '0;
                  bidx_q <= bidx_q + 1'b1;
                  if (left_q != '0) left_q <= left_q - 1'b1;
                  if (bidx_q == PG_LOG'(PAGE_BYTES - 1)) phase_q <= PH_WTAIL;
               end
               PH_POLL: begin
                  step_q <= '0;
                  if (ready) begin
                     addr_q <= addr_q + ADDR_W'(PAGE_BYTES);
                     if (op_q == OP_ERASE || left_q == '0) phase_q <= PH_LEAVE;
                     else                                  phase_q <= PH_WHEAD;
                  end else if (expired) begin
                     err_q   <= 1'b1;
                     phase_q <= PH_LEAVE;
                  end
               end
               PH_LEAVE: if (last) begin
                  step_q <= '0;
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign scan_req   = busy_q;
   assign scan_is_ir = cur.is_ir;
   assign scan_len   = cur.len;
   assign scan_din   = cur.bits;
   assign byte_pop   = busy_q && scan_ack && phase_q == PH_WDATA && left_q != '0;
   assign busy       = busy_q;
   assign done       = done_q;
   assign error      = err_q;

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_req && !scan_ack |=> scan_req && $stable(scan_din) && $stable(scan_len) && $stable(scan_is_ir));
   // R1
   ir_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_req && scan_is_ir |-> scan_len == 6'd4);
   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R5
   pop_dr8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_pop |-> scan_ack && !scan_is_ir && scan_len == 6'd8);
   // R8
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && op_valid && op_code == 2'b10 && |op_addr[PG_LOG-1:0] |=> done && error && !busy && !scan_req);
   // R11
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && op_valid && (op_code == 2'b00 || op_code == 2'b11) |=> !busy && !done);

endmodule

// File: tb/test_jtag_flash_seq.sv
`timescale 1ns/1ps
module test_jtag_flash_seq;

   localparam int P    = 8;
   localparam int MAXP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = 2'b00;
   logic [16:0] op_addr = '0;
   logic [7:0]  op_count = '0;
   logic [7:0]  byte_data;
   logic        byte_pop;
   logic        scan_req, scan_is_ir;
   logic [5:0]  scan_len;
   logic [31:0] scan_din;
   logic        scan_ack = 1'b0;
   logic [31:0] scan_dout = '0;
   logic        busy, done, error;

   always #10 clk = ~clk;

   jtag_flash_seq #(.PAGE_BYTES(P), .MAX_POLL(MAXP), .ADDR_W(17), .CNT_W(8)) i_jtag_flash_seq (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_addr(op_addr), .op_count(op_count), .byte_data(byte_data), .byte_pop(byte_pop),
      .scan_req(scan_req), .scan_is_ir(scan_is_ir), .scan_len(scan_len), .scan_din(scan_din),
      .scan_ack(scan_ack), .scan_dout(scan_dout), .busy(busy), .done(done), .error(error)
   );

   int tests = 0, fails = 0;
   logic [7:0] src [32];
   int pops = 0;
   int base = 0;
   bit q_ir[$];
   int q_len[$];
   int q_din[$];
   int q_dout[$];
   string q_tag[$];
   bit running = 0, fin_pending = 0, chk_done = 1;
   int wait_cnt = 0, nsc = 0;
   bit exp_err;
   int exp_bytes;

   always @(posedge clk) if (byte_pop) pops <= pops + 1;
   assign byte_data = src[(pops - base) % 32];

   task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic add(input bit ir, input int len, input int din, input int dout, input string tag);
      q_ir.push_back(ir); q_len.push_back(len); q_din.push_back(din);
      q_dout.push_back(dout); q_tag.push_back(tag);
   endtask

   task automatic add_enter();
      add(1, 4, 'hC, 0, "R1/R2"); add(0, 1, 1, 0, "R2");
      add(1, 4, 'h4, 0, "R1/R2"); add(0, 16, 'hA370, 0, "R2");
   endtask

   task automatic add_leave();
      add(1, 4, 'h5, 0, "R13"); add(0, 15, 'h2300, 0, "R13"); add(0, 15, 'h3300, 0, "R13");
      add(1, 4, 'h4, 0, "R13"); add(0, 16, 0, 0, "R13");
      add(1, 4, 'hC, 0, "R13"); add(0, 1, 0, 0, "R13");
   endtask

   task automatic add_poll(input int word, input int k, output bit ok);
      ok = 0;
      for (int i = 0; i < MAXP; i++) begin
         add(0, 15, word, (i == k) ? 32'h0000_0200 : 32'hFFFF_FDFF, "R9/poll");
         if (i == k) begin ok = 1; break; end
      end
   endtask

   task automatic build_erase(input int k);
      bit ok;
      add_enter();
      add(1, 4, 'h5, 0, "R3"); add(0, 15, 'h2380, 0, "R3"); add(0, 15, 'h3180, 0, "R3");
      add(0, 15, 'h3380, 0, "R3"); add(0, 15, 'h3380, 0, "R3");
      add_poll('h3380, k, ok);
      add_leave();
      exp_err = !ok; exp_bytes = 0;
   endtask

   task automatic build_write(input int addr, input int count, input int k);
      int left = count, a = addr, bp = 0;
      bit ok = 1;
      add_enter();
      while (left > 0 && ok) begin
         add(1, 4, 'h5, 0, "R4"); add(0, 15, 'h2310, 0, "R4");
         add(0, 15, 'h0700 | ((a >> 9) & 'hFF), 0, "R4");
         add(0, 15, 'h0300 | ((a >> 1) & 'hFF), 0, "R4");
         add(1, 4, 'h6, 0, "R1/R4");
         for (int j = 0; j < P; j++) begin
            if (left > 0) begin add(0, 8, src[bp], 0, "R5"); bp++; left--; end
            else add(0, 8, 'hFF, 0, "R5 pad");
         end
         add(1, 4, 'h5, 0, "R6"); add(0, 15, 'h3700, 0, "R6"); add(0, 15, 'h3500, 0, "R6");
         add(0, 15, 'h3700, 0, "R6"); add(0, 15, 'h3700, 0, "R6");
         add_poll('h3700, k, ok);
         a += P;
      end
      add_leave();
      exp_err = !ok; exp_bytes = bp;
   endtask

   // shift engine model and per-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_done) chk(done == fin_pending, "R12", "done", done, fin_pending);
         if (fin_pending) begin
            chk(!busy, "R12", "busy at done", busy, 0);
            fin_pending = 0; running = 0;
         end else if (running) begin
            chk(busy, "R12", "busy while running", busy, 1);
         end
         if (scan_ack) begin
            scan_ack = 0; wait_cnt = nsc % 3;
         end else if (scan_req) begin
            if (q_ir.size() == 0) chk(0, "R10", "unexpected scan", scan_din, 0);
            else if (wait_cnt > 0) wait_cnt--;
            else begin
               chk(scan_is_ir == q_ir[0] && scan_len == 6'(q_len[0]) && scan_din == 32'(q_din[0]),
                   q_tag[0], "scan {ir,len,din}", {scan_is_ir, scan_len, scan_din},
                   {q_ir[0], 6'(q_len[0]), 32'(q_din[0])});
               scan_dout = q_dout[0];
               void'(q_ir.pop_front()); void'(q_len.pop_front()); void'(q_din.pop_front());
               void'(q_dout.pop_front()); void'(q_tag.pop_front());
               scan_ack = 1; nsc++;
               if (q_ir.size() == 0) fin_pending = 1;
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk); #5;
   endtask

   task automatic start_op(input logic [1:0] code, input int addr, input int count);
      base = pops;
      op_code = code; op_addr = 17'(addr); op_count = 8'(count); op_valid = 1;
      tick();
      op_valid = 0; op_code = 0;
      running = 1;
   endtask

   task automatic wait_op(input string tag);
      int guard = 0;
      while (running && guard < 5000) begin tick(); guard++; end
      chk(!running, tag, "finished", running, 0);
      chk(error == exp_err, tag, "error", error, exp_err);
      chk(pops - base == exp_bytes, tag, "bytes consumed", pops - base, exp_bytes);
      chk(q_ir.size() == 0, tag, "scans left", q_ir.size(), 0);
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) src[i] = 8'(i * 37 + 5);
      tick(); tick();
      chk(!busy && !done && !error && !scan_req && !byte_pop, "R12", "reset outputs",
          {busy, done, error, scan_req, byte_pop}, 0);
      rst_n = 1;
      tick();

      build_erase(0);             start_op(2'b01, 0, 0);        wait_op("R3");
      build_erase(2);             start_op(2'b01, 0, 0);        wait_op("R3");
      build_write('h40, 8, 1);    start_op(2'b10, 'h40, 8);     wait_op("R5");
      build_write('h1F8, 13, 0);  start_op(2'b10, 'h1F8, 13);   wait_op("R7");
      build_write('h10, 0, 0);    start_op(2'b10, 'h10, 0);     wait_op("R7");

      // R8 misaligned write
      chk_done = 0;
      op_code = 2'b10; op_addr = 17'h13; op_count = 8'd4; op_valid = 1;
      tick();
      op_valid = 0; op_code = 0;
      chk(done && error && !busy && !scan_req, "R8", "reject {done,err,busy,req}",
          {done, error, busy, scan_req}, 4'b1100);
      tick();
      chk(!done && !scan_req, "R8", "no scans after reject", {done, scan_req}, 0);
      chk_done = 1;

      // R9 timeouts
      build_erase(99);            start_op(2'b01, 0, 0);        wait_op("R9");
      build_write(0, 20, 99);     start_op(2'b10, 0, 20);       wait_op("R9");
      chk(error, "R12", "error held", error, 1);
      tick(); tick();
      chk(error, "R12", "error held idle", error, 1);

      // R11 ignored while busy; error cleared on accept
      build_write('h80, 5, 1);    start_op(2'b10, 'h80, 5);
      chk(!error, "R12", "error cleared", error, 0);
      tick(); tick(); tick();
      op_code = 2'b01; op_valid = 1; tick(); op_valid = 0; op_code = 0;
      wait_op("R11");

      // R11 reserved codes ignored
      op_code = 2'b11; op_valid = 1; tick(); op_valid = 0;
      op_code = 2'b00; op_valid = 1; tick(); op_valid = 0;
      tick();
      chk(!busy && !scan_req && !done, "R11", "reserved ignored", {busy, scan_req, done}, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule